// File: doc/BRIEF.md
# Access Rights Checker

This unit sits behind a translation lookup. Once an entry has matched, it receives that entry's rights fields together with the request being made: the current privilege, the kind of access, its size and the low address bits. From these it computes the set of accesses the page grants, and then either clears the request or names the single fault that must be taken. It also decides whether an instruction fetch from a gateway page lowers the privilege number.

The result is registered. A request presented with `reqValid` high in one cycle yields its permission vector, fault flag, fault code, fetch-fault marker and privilege outcome in the next cycle, with `rspValid` high. The protection-ID registers are provided as a flat bus of 64-bit words. In wide mode both halves of each word take part in matching; in narrow mode only the low half does.

Top module: `acc_rights_unit`

## Requirements
- R1: A request sampled with `reqValid` high gives its result on the outputs one clock later, with `rspValid` high. A cycle without a request drives `rspValid` low next cycle, and every other output keeps its previous value.
- R2: Privilege bands (a smaller number means more privilege). Read needs curPriv <= pl1. Write needs curPriv <= pl2. Execute needs pl2 <= curPriv <= pl1.
- R3: The type field narrows the privilege result to give `permVec` = {exec, write, read}. Type 0 allows read. Type 1 allows read and write. Type 2 allows read and execute. Type 3 allows all three. Types 4 to 7 allow execute only.
- R4: Access kind is encoded as 0 load, 1 store, 2 fetch, 3 load. If the bit of `permVec` for the requested kind is clear, the fault code is 1. `faultInstr` is high whenever a fault is reported on a fetch.
- R5: An access ID of zero marks the page public, and no ID check is made. Otherwise the ID, zero-extended to 32 bits, must equal the low 32-bit half of one protection-ID word. In wide mode it may instead equal the upper half. When there is no match, the fault code is 2.
- R6: A set reference-trap bit gives fault code 3 for every access kind.
- R7: A store to an entry whose dirty bit is clear gives fault code 4.
- R8: A set break bit gives fault code 5 on loads and stores, unless `breakSuppress` is high. Fetches never raise it.
- R9: If the address is not a multiple of 2^`accSizeLog` bytes, judged on `addrLow`, the fault code is 6.
- R10: When several faults apply together, only the lowest code among them is reported. `faultValid` is high exactly when the code is non-zero.
- R11: A fetch from a type 4 to 7 page that raises no fault, and whose type low bits are below curPriv, sets `privChange` and gives `newPriv` = type low bits. In every other case `newPriv` = curPriv and `privChange` is low.
- R12: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| curPriv | input | 2 | Current privilege number |
| accKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| accSizeLog | input | 2 | log2 of access size in bytes |
| addrLow | input | 3 | Low address bits |
| entType | input | 3 | Entry rights type |
| entPl1 | input | 2 | Read/execute upper privilege bound |
| entPl2 | input | 2 | Write bound and execute lower bound |
| entAid | input | 16 | Entry access ID, 0 = public |
| entRefTrap | input | 1 | Reference-trap bit |
| entDirty | input | 1 | Dirty bit |
| entBreak | input | 1 | Break bit |
| wideMode | input | 1 | Match upper halves of ID words too |
| pidRegs | input | 256 | Four 64-bit protection-ID words |
| breakSuppress | input | 1 | Suppresses the break fault |
| rspValid | output | 1 | Result valid |
| permVec | output | 3 | Granted {exec, write, read} |
| faultValid | output | 1 | A fault is reported |
| faultCode | output | 3 | 0 none, 1 to 6 by priority |
| faultInstr | output | 1 | Reported fault was on a fetch |
| newPriv | output | 2 | Privilege after this access |
| privChange | output | 1 | Gateway promotion taken |

## Verification
The functions most likely to coincide are the fault priority chain and the gateway promotion. A fetch from a gateway page can carry a reference-trap bit or fall outside its privilege window in the same cycle that it would promote. Directed vectors pair every fault with each lower-priority fault, and pair gateway fetches with faults. The scoreboard model then requires that only the lowest code appears and that a faulted gateway fetch leaves the privilege unchanged. Several hundred random vectors, drawn with an ID pool small enough to produce both hits and misses, stack faults at random on top of these cases.

// File: rtl/acc_rights_pkg.sv
package acc_rights_pkg;
  localparam int PRIV_W = 2;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_ALT   = 2'd3
  } accKind_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_RIGHTS  = 3'd1,
    FC_PROTID  = 3'd2,
    FC_REFTRAP = 3'd3,
    FC_DIRTY   = 3'd4,
    FC_BREAK   = 3'd5,
    FC_ALIGN   = 3'd6
  } faultCode_e;

  // conditions found by the datapath, judged by the control
  typedef struct packed {
    logic rightsBad;
    logic pidBad;
    logic refTrap;
    logic dirtyBad;
    logic breakHit;
    logic misAligned;
    logic isFetch;
    logic gateLower;
  } condFlags_t;

  // strobes from control back into the datapath
  typedef struct packed {
    logic       capture;
    logic       gateApply;
    faultCode_e code;
  } ctlStrobes_t;
endpackage

// File: rtl/acc_rights_dp.sv
module acc_rights_dp
  import acc_rights_pkg::*;
#(
  parameter int AID_W     = 16,
  parameter int PID_CNT   = 4,
  parameter int PID_W     = 64,
  parameter int ADDR_LO_W = 3,
  parameter int SIZE_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PRIV_W-1:0]        curPriv,
  input  logic [1:0]               accKind,
  input  logic [SIZE_W-1:0]        accSizeLog,
  input  logic [ADDR_LO_W-1:0]     addrLow,
  input  logic [2:0]               entType,
  input  logic [PRIV_W-1:0]        entPl1,
  input  logic [PRIV_W-1:0]        entPl2,
  input  logic [AID_W-1:0]         entAid,
  input  logic                     entRefTrap,
  input  logic                     entDirty,
  input  logic                     entBreak,
  input  logic                     wideMode,
  input  logic [PID_CNT*PID_W-1:0] pidRegs,
  input  logic                     breakSuppress,
  input  ctlStrobes_t              strobes,
  output condFlags_t               flags,
  output logic                     rspValid,
  output logic [2:0]               permVec,
  output logic                     faultValid,
  output logic [2:0]               faultCode,
  output logic                     faultInstr,
  output logic [PRIV_W-1:0]        newPriv,
  output logic                     privChange
);
  localparam int HALF_W = PID_W / 2;

  logic [2:0] typeMask;
  logic [2:0] privOk;
  logic [2:0] permNow;
  logic       wantedOk;
  logic [PID_CNT-1:0] loHit;
  logic [PID_CNT-1:0] hiHit;
  logic [HALF_W-1:0]  aidWide;
  logic [ADDR_LO_W-1:0] sizeMask;

  assign aidWide = HALF_W'(entAid);

  for (genvar g = 0; g < PID_CNT; g++) begin : g_pid
    assign loHit[g] = (pidRegs[g*PID_W +: HALF_W] == aidWide);
    assign hiHit[g] = (pidRegs[g*PID_W + HALF_W +: HALF_W] == aidWide);
  end

  always_comb begin
    unique case (entType)
      3'd0:    typeMask = 3'b001;
      3'd1:    typeMask = 3'b011;
      3'd2:    typeMask = 3'b101;
      3'd3:    typeMask = 3'b111;
      default: typeMask = 3'b100;
    endcase
  end

  assign privOk[0] = (curPriv <= entPl1);
  assign privOk[1] = (curPriv <= entPl2);
  assign privOk[2] = (entPl2 <= curPriv) && (curPriv <= entPl1);
  assign permNow   = typeMask & privOk;

  always_comb begin
    unique case (accKind)
      KIND_STORE: wantedOk = permNow[1];
      KIND_FETCH: wantedOk = permNow[2];
      default:    wantedOk = permNow[0];
    endcase
  end

  assign sizeMask = ADDR_LO_W'((1 << accSizeLog) - 1);

  always_comb begin
    flags.isFetch    = (accKind == KIND_FETCH);
    flags.rightsBad  = !wantedOk;
    flags.pidBad     = (entAid != '0) && !(|loHit || (wideMode && |hiHit));
    flags.refTrap    = entRefTrap;
    flags.dirtyBad   = (accKind == KIND_STORE) && !entDirty;
    flags.breakHit   = entBreak && !flags.isFetch && !breakSuppress;
    flags.misAligned = |(addrLow & sizeMask);
    flags.gateLower  = entType[2] && (PRIV_W'(entType[1:0]) < curPriv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      permVec    <= '0;
      faultValid <= 1'b0;
      faultCode  <= '0;
      faultInstr <= 1'b0;
      newPriv    <= '0;
      privChange <= 1'b0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        permVec    <= permNow;
        faultValid <= (strobes.code != FC_NONE);
        faultCode  <= strobes.code;
        faultInstr <= (strobes.code != FC_NONE) && flags.isFetch;
        newPriv    <= strobes.gateApply ? PRIV_W'(entType[1:0]) : curPriv;
        privChange <= strobes.gateApply;
      end
    end
  end
endmodule

// File: rtl/acc_rights_ctl.sv
module acc_rights_ctl
  import acc_rights_pkg::*;
(
  input  logic        reqValid,
  input  condFlags_t  flags,
  output ctlStrobes_t strobes
);
  faultCode_e pick;

  always_comb begin
    if (flags.rightsBad)       pick = FC_RIGHTS;
    else if (flags.pidBad)     pick = FC_PROTID;
    else if (flags.refTrap)    pick = FC_REFTRAP;
    else if (flags.dirtyBad)   pick = FC_DIRTY;
    else if (flags.breakHit)   pick = FC_BREAK;
    else if (flags.misAligned) pick = FC_ALIGN;
    else                       pick = FC_NONE;
  end

  always_comb begin
    strobes.capture   = reqValid;
    strobes.code      = pick;
    strobes.gateApply = reqValid && flags.isFetch && flags.gateLower && (pick == FC_NONE);
  end
endmodule

// File: rtl/acc_rights_unit.sv
module acc_rights_unit
  import acc_rights_pkg::*;
#(
  parameter int AID_W     = 16,
  parameter int PID_CNT   = 4,
  parameter int PID_W     = 64,
  parameter int ADDR_LO_W = 3,
  parameter int SIZE_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  input  logic [PRIV_W-1:0]        curPriv,
  input  logic [1:0]               accKind,
  input  logic [SIZE_W-1:0]        accSizeLog,
  input  logic [ADDR_LO_W-1:0]     addrLow,
  input  logic [2:0]               entType,
  input  logic [PRIV_W-1:0]        entPl1,
  input  logic [PRIV_W-1:0]        entPl2,
  input  logic [AID_W-1:0]         entAid,
  input  logic                     entRefTrap,
  input  logic                     entDirty,
  input  logic                     entBreak,
  input  logic                     wideMode,
  input  logic [PID_CNT*PID_W-1:0] pidRegs,
  input  logic                     breakSuppress,
  output logic                     rspValid,
  output logic [2:0]               permVec,
  output logic                     faultValid,
  output logic [2:0]               faultCode,
  output logic                     faultInstr,
  output logic [PRIV_W-1:0]        newPriv,
  output logic                     privChange
);
  condFlags_t  flags;
  ctlStrobes_t strobes;

  acc_rights_ctl u_ctl (
    .reqValid (reqValid),
    .flags    (flags),
    .strobes  (strobes)
  );

  acc_rights_dp #(
    .AID_W(AID_W), .PID_CNT(PID_CNT), .PID_W(PID_W),
    .ADDR_LO_W(ADDR_LO_W), .SIZE_W(SIZE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .curPriv(curPriv), .accKind(accKind),
    .accSizeLog(accSizeLog), .addrLow(addrLow), .entType(entType),
    .entPl1(entPl1), .entPl2(entPl2), .entAid(entAid),
    .entRefTrap(entRefTrap), .entDirty(entDirty), .entBreak(entBreak),
    .wideMode(wideMode), .pidRegs(pidRegs), .breakSuppress(breakSuppress),
    .strobes(strobes), .flags(flags), .rspValid(rspValid),
    .permVec(permVec), .faultValid(faultValid), .faultCode(faultCode),
    .faultInstr(faultInstr), .newPriv(newPriv), .privChange(privChange)
  );
endmodule

// File: rtl/acc_rights_chk.sv
module acc_rights_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic [1:0] accKind,
  input logic [1:0] curPriv,
  input logic [1:0] entPl2,
  input logic       entRefTrap,
  input logic       rspValid,
  input logic [2:0] permVec,
  input logic       faultValid,
  input logic [2:0] faultCode,
  input logic [1:0] newPriv,
  input logic       privChange
);
  logic pastOk;
  always_ff @(posedge clk) pastOk <= rst_n;

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk |-> rspValid == $past(reqValid));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && !$past(reqValid) |->
      $stable(faultCode) && $stable(permVec) && $stable(newPriv) && $stable(privChange));

  // R4
  store_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && rspValid && $past(accKind) == 2'd1 && $past(curPriv) > $past(entPl2)
      |-> faultCode == 3'd1);

  // R6
  ref_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && rspValid && $past(entRefTrap) |-> faultValid && faultCode <= 3'd3);

  // R11
  gate_lower_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && rspValid && privChange |-> newPriv < $past(curPriv));

  // R11
  gate_fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && faultValid |-> !privChange);
endmodule

bind acc_rights_unit acc_rights_chk u_chk (.*);

// File: tb/sim_acc_rights_unit.sv
module sim_acc_rights_unit;
  typedef struct packed {
    logic [1:0]  priv;
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [2:0]  addr;
    logic [2:0]  typ;
    logic [1:0]  pl1;
    logic [1:0]  pl2;
    logic [15:0] aid;
    logic        t, d, b, wide, xsup;
  } vec_t;

  typedef struct packed {
    logic [2:0] perm;
    logic       fv;
    logic [2:0] code;
    logic       finstr;
    logic [1:0] npriv;
    logic       pchg;
  } exp_t;

  logic clk = 0, rst_n = 0, reqValid = 0;
  logic [1:0] curPriv = 0, accKind = 0, accSizeLog = 0, entPl1 = 0, entPl2 = 0;
  logic [2:0] addrLow = 0, entType = 0;
  logic [15:0] entAid = 0;
  logic entRefTrap = 0, entDirty = 0, entBreak = 0, wideMode = 0, breakSuppress = 0;
  logic [255:0] pidRegs = '0;
  logic rspValid, faultValid, faultInstr, privChange;
  logic [2:0] permVec, faultCode;
  logic [1:0] newPriv;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  exp_t sbQ[$];
  string tagQ[$];
  exp_t lastExp;

  always #5 clk = ~clk;

  acc_rights_unit u0 (.*);

  function automatic exp_t model(vec_t v, output string tag);
    exp_t e;
    logic canR, canW, canX, want, pidOk, misal;
    canR = (v.typ <= 3'd3) && (v.priv <= v.pl1);
    canW = (v.typ == 3'd1 || v.typ == 3'd3) && (v.priv <= v.pl2);
    canX = (v.typ == 3'd2 || v.typ >= 3'd3) && (v.pl2 <= v.priv) && (v.priv <= v.pl1);
    want = (v.kind == 2'd1) ? canW : (v.kind == 2'd2) ? canX : canR;
    pidOk = (v.aid == 16'd0);
    for (int i = 0; i < 4; i++) begin
      if (pidRegs[i*64 +: 32] == {16'd0, v.aid}) pidOk = 1;
      if (v.wide && pidRegs[i*64+32 +: 32] == {16'd0, v.aid}) pidOk = 1;
    end
    misal = (v.addr % (3'd1 << v.size)) != 0;
    e.perm = {canX, canW, canR};
    if (!want)                                  begin e.code = 3'd1; tag = "R4"; end
    else if (!pidOk)                            begin e.code = 3'd2; tag = "R5"; end
    else if (v.t)                               begin e.code = 3'd3; tag = "R6"; end
    else if (v.kind == 2'd1 && !v.d)            begin e.code = 3'd4; tag = "R7"; end
    else if (v.b && v.kind != 2'd2 && !v.xsup)  begin e.code = 3'd5; tag = "R8"; end
    else if (misal)                             begin e.code = 3'd6; tag = "R9"; end
    else                                        begin e.code = 3'd0; tag = "R2"; end
    e.fv = (e.code != 0);
    e.finstr = e.fv && (v.kind == 2'd2);
    e.pchg = !e.fv && v.kind == 2'd2 && v.typ >= 3'd4 && (v.typ[1:0] < v.priv);
    e.npriv = e.pchg ? v.typ[1:0] : v.priv;
    if (e.pchg) tag = "R11";
    return e;
  endfunction

  task automatic send(vec_t v);
    string tag;
    exp_t e;
    curPriv = v.priv; accKind = v.kind; accSizeLog = v.size; addrLow = v.addr;
    entType = v.typ; entPl1 = v.pl1; entPl2 = v.pl2; entAid = v.aid;
    entRefTrap = v.t; entDirty = v.d; entBreak = v.b; wideMode = v.wide;
    breakSuppress = v.xsup; reqValid = 1;
    e = model(v, tag);
    sbQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
    @(negedge clk);
  endtask

  // monitor: pops one expected item per valid response
  always @(negedge clk) begin
    if (rst_n && rspValid && !done) begin
      exp_t e, a;
      string tag;
      a = '{permVec, faultValid, faultCode, faultInstr, newPriv, privChange};
      nChecks++;
      if (sbQ.size() == 0) begin
        nFails++;
        $display("FAIL R1: response without request, actual %h expected none", a);
      end else begin
        e = sbQ.pop_front();
        tag = tagQ.pop_front();
        if (a !== e) begin
          nFails++;
          $display("FAIL %s (R10 priority): actual %h expected %h", tag, a, e);
        end
      end
    end
  end

  function automatic logic [63:0] mkPid(logic [15:0] lo, logic [15:0] hi);
    return {16'd0, hi, 16'd0, lo};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    vec_t base, v;
    pidRegs = {mkPid(16'h0400, 16'h0500), mkPid(16'h0300, 16'h0000),
               mkPid(16'h0200, 16'h0600), mkPid(16'h0100, 16'h0700)};
    repeat (3) @(negedge clk);
    // R12 reset state
    nChecks++;
    if ({rspValid, permVec, faultValid, faultCode, faultInstr, newPriv, privChange} !== '0) begin
      nFails++;
      $display("FAIL R12: actual %b expected 0",
               {rspValid, permVec, faultValid, faultCode, faultInstr, newPriv, privChange});
    end
    rst_n = 1;
    @(negedge clk);

    base = '0;
    base.typ = 3'd3; base.pl1 = 2'd3; base.pl2 = 2'd0; base.d = 1'b1; base.priv = 2'd0;
    // R2 / R3 plain accesses
    v = base; send(v);
    v = base; v.kind = 2'd1; send(v);
    v = base; v.kind = 2'd3; v.priv = 2'd2; v.pl1 = 2'd2; send(v);
    // R2 read above pl1
    v = base; v.priv = 2'd3; v.pl1 = 2'd2; send(v);
    // R2 write above pl2 (R4)
    v = base; v.kind = 2'd1; v.priv = 2'd2; v.pl2 = 2'd1; send(v);
    // R2 exec below window and inside window
    v = base; v.kind = 2'd2; v.priv = 2'd0; v.pl2 = 2'd1; send(v);
    v = base; v.kind = 2'd2; v.priv = 2'd1; v.pl2 = 2'd1; v.pl1 = 2'd2; send(v);
    // R3 type 0 store, type 2 store, type 1 fetch, type 4 load
    v = base; v.typ = 3'd0; v.kind = 2'd1; send(v);
    v = base; v.typ = 3'd2; v.kind = 2'd1; send(v);
    v = base; v.typ = 3'd1; v.kind = 2'd2; send(v);
    v = base; v.typ = 3'd4; v.kind = 2'd0; send(v);
    // R5 ID: public, low hit, miss, upper only narrow/wide
    v = base; v.aid = 16'h0200; send(v);
    v = base; v.aid = 16'h0999; send(v);
    v = base; v.aid = 16'h0600; send(v);
    v = base; v.aid = 16'h0600; v.wide = 1; send(v);
    // R6 ref trap on each kind
    v = base; v.t = 1; send(v);
    v = base; v.t = 1; v.kind = 2'd2; send(v);
    // R7 dirty
    v = base; v.d = 0; v.kind = 2'd1; send(v);
    v = base; v.d = 0; v.kind = 2'd0; send(v);
    // R8 break: load, suppressed, fetch
    v = base; v.b = 1; send(v);
    v = base; v.b = 1; v.xsup = 1; send(v);
    v = base; v.b = 1; v.kind = 2'd2; send(v);
    // R9 alignment
    v = base; v.size = 2'd3; v.addr = 3'd4; send(v);
    v = base; v.size = 2'd2; v.addr = 3'd4; send(v);
    v = base; v.size = 2'd1; v.addr = 3'd1; send(v);
    // R10 stacked faults
    v = base; v.priv = 2'd3; v.pl1 = 2'd1; v.t = 1; v.aid = 16'h0999; send(v);
    v = base; v.aid = 16'h0999; v.t = 1; send(v);
    v = base; v.kind = 2'd1; v.t = 1; v.d = 0; send(v);
    v = base; v.kind = 2'd1; v.d = 0; v.b = 1; v.addr = 3'd1; v.size = 2'd1; send(v);
    v = base; v.b = 1; v.addr = 3'd2; v.size = 2'd2; send(v);
    // R11 gateway promotion and blocks
    v = base; v.typ = 3'd5; v.kind = 2'd2; v.priv = 2'd3; send(v);
    v = base; v.typ = 3'd6; v.kind = 2'd2; v.priv = 2'd1; send(v);
    v = base; v.typ = 3'd4; v.kind = 2'd2; v.priv = 2'd3; v.t = 1; send(v);
    v = base; v.typ = 3'd4; v.kind = 2'd2; v.priv = 2'd3; v.pl1 = 2'd2; send(v);
    // random mix
    for (int i = 0; i < 400; i++) begin
      v.priv = 2'($urandom); v.kind = 2'($urandom); v.size = 2'($urandom);
      v.addr = 3'($urandom); v.typ = 3'($urandom); v.pl1 = 2'($urandom);
      v.pl2 = 2'($urandom);
      v.aid = ($urandom % 3 == 0) ? 16'd0 : 16'(($urandom % 8) * 16'h0100);
      v.t = ($urandom % 5 == 0); v.d = ($urandom % 4 != 0); v.b = ($urandom % 4 == 0);
      v.wide = 1'($urandom); v.xsup = 1'($urandom);
      send(v);
    end
    // R1 idle hold
    reqValid = 0;
    entRefTrap = ~entRefTrap; curPriv = ~curPriv; entType = ~entType;
    repeat (3) @(negedge clk);
    nChecks++;
    if (rspValid !== 1'b0 ||
        {permVec, faultValid, faultCode, faultInstr, newPriv, privChange} !== lastExp) begin
      nFails++;
      $display("FAIL R1: actual %b/%h expected 0/%h", rspValid,
               {permVec, faultValid, faultCode, faultInstr, newPriv, privChange}, lastExp);
    end
    nChecks++;
    if (sbQ.size() != 0) begin
      nFails++;
      $display("FAIL R1: actual %0d pending expected 0", sbQ.size());
    end
    report();
  end
endmodule